// File: doc/BRIEF.md
# Ready-Gated Controlled Clock Generator

This block produces a free-running reference clock and three controlled clocks derived from it. It runs on a base clock at twice the reference rate, so it can place edges on either half of a reference period. The three controlled clocks are:

- a fast clock whose active edge is rising;
- a fast clock whose active edge is falling;
- a slow clock that divides the reference by an integer ratio and has a fixed duty cycle.

Two stall inputs hold back the edges that matter to downstream logic. One gates rising-edge activity and the other gates falling-edge activity.

The two fast clocks run at the reference rate and have a don't-care duty cycle. Only their active edge is tied to a reference rising edge and can be stalled. Their opposite edge lands on a reference falling edge and always happens. Both edges of the slow clock are care edges. Either stall therefore freezes it.

A held edge is delayed, not lost. The slow clock's phase counter does not move while its edge is held, so the divide ratio is kept once both stall inputs are released. One flag per controlled clock reports, at each reference rising edge, whether that clock's care edge was allowed.

Top module: `ready_clkgen`

## Requirements
- R1: `uclk` toggles on every base clock edge out of reset. Its first rising edge comes on the first base edge after reset is released.
- R2: `clk_fr` rises at a reference rising edge only if `rdy_pos` is high there, and it always returns low at the next reference falling edge. `rdy_neg` has no effect on it.
- R3: `clk_fn` rises at every reference falling edge whatever the stall inputs are. It falls at a reference rising edge only if `rdy_neg` is high there, and otherwise stays high. `rdy_pos` has no effect on it.
- R4: `clk_slow` advances one step at each reference rising edge where both `rdy_pos` and `rdy_neg` are high, and keeps its level at any other. With ratio N, any run of 3N consecutive advancing reference periods holds exactly 3 rising edges.
- R5: After G advancing reference rising edges since reset, `clk_slow` has had (G+N-1)/N rising edges. It has had (G-1-N/2)/N+1 falling edges when G > N/2, and none otherwise. Integer division is used. The high phase lasts N/2 reference periods.
- R6: Every rising edge of `clk_fr`, every falling edge of `clk_fn` and every edge of `clk_slow` coincides with a rising edge of `uclk`.
- R7: At each reference rising edge, `en_fr` takes the value of `rdy_pos`, `en_fn` takes `rdy_neg`, and `en_slow` takes their AND. The three flags never change at a reference falling edge.
- R8: A synchronous active-high `rst` drives `uclk`, all controlled clocks and all flags low, and clears the slow clock's phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, twice the reference rate |
| rst | input | 1 | Synchronous active-high reset |
| rdy_pos | input | 1 | Stall input for rising care edges (low holds them) |
| rdy_neg | input | 1 | Stall input for falling care edges (low holds them) |
| uclk | output | 1 | Free-running reference clock |
| clk_fr | output | 1 | Fast controlled clock, rising active edge |
| clk_fn | output | 1 | Fast controlled clock, falling active edge |
| clk_slow | output | 1 | Divided controlled clock, ratio RATIO |
| en_fr | output | 1 | Care edge of `clk_fr` allowed at last reference rise |
| en_fn | output | 1 | Care edge of `clk_fn` allowed at last reference rise |
| en_slow | output | 1 | Care edge of `clk_slow` allowed at last reference rise |

## Verification
The assertions check the following on every cycle:
- the reference keeps toggling;
- each stall freezes exactly the clocks it governs;
- the don't-care edges of the fast clocks always fire;
- no care edge lands off a reference rising edge;
- the flags hold still across reference falling edges.

Only the bench scenarios can show the long-range properties:
- the slow clock keeps its phase through stalls of varying length and starting phase;
- its edge counts match the ratio formula after release;
- reset clears that phase in the middle of a run.

// File: rtl/ready_clkgen.sv
module ready_clkgen #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_pos,
  input  logic rdy_neg,
  output logic uclk,
  output logic clk_fr,
  output logic clk_fn,
  output logic clk_slow,
  output logic en_fr,
  output logic en_fn,
  output logic en_slow
);
  localparam int CW = (RATIO < 2) ? 1 : $clog2(RATIO);
  localparam logic [CW-1:0] HI   = CW'(RATIO / 2);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic          u_q, fr_q, fn_q, sl_q;
  logic          efr_q, efn_q, esl_q;
  logic [CW-1:0] cnt;
  logic          rise, go;

  assign rise = ~u_q;
  assign go   = rdy_pos & rdy_neg;

  always_ff @(posedge clk) begin
    if (rst) begin
      u_q   <= 1'b0;
      fr_q  <= 1'b0;
      fn_q  <= 1'b0;
      sl_q  <= 1'b0;
      efr_q <= 1'b0;
      efn_q <= 1'b0;
      esl_q <= 1'b0;
      cnt   <= '0;
    end else begin
      u_q <= ~u_q;
      if (rise) begin
        efr_q <= rdy_pos;
        efn_q <= rdy_neg;
        esl_q <= go;
        if (rdy_pos) fr_q <= 1'b1;
        if (rdy_neg) fn_q <= 1'b0;
        if (go) begin
          sl_q <= (cnt < HI);
          cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
      end else begin
        fr_q <= 1'b0;
        fn_q <= 1'b1;
      end
    end
  end

  assign uclk     = u_q;
  assign clk_fr   = fr_q;
  assign clk_fn   = fn_q;
  assign clk_slow = sl_q;
  assign en_fr    = efr_q;
  assign en_fn    = efn_q;
  assign en_slow  = esl_q;
endmodule

module ready_clkgen_chk (
  input logic clk,
  input logic rst,
  input logic rdy_pos,
  input logic rdy_neg,
  input logic uclk,
  input logic clk_fr,
  input logic clk_fn,
  input logic clk_slow,
  input logic en_fr,
  input logic en_fn,
  input logic en_slow
);
  p_uclk_toggle_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (uclk != $past(uclk)));

  p_fr_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (!uclk && !rdy_pos) |=> !clk_fr);

  p_fr_free_fall_r2: assert property (@(posedge clk) disable iff (rst)
    uclk |=> !clk_fr);

  p_fn_free_rise_r3: assert property (@(posedge clk) disable iff (rst)
    uclk |=> clk_fn);

  p_fn_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!uclk && !rdy_neg && clk_fn) |=> clk_fn);

  p_slow_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!uclk && !(rdy_pos && rdy_neg)) |=> $stable(clk_slow));

  p_fr_grid_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_fr) |-> $rose(uclk));

  p_fn_grid_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_fn) |-> $rose(uclk));

  p_slow_grid_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_slow) |-> $rose(uclk));

  p_en_sync_r7: assert property (@(posedge clk) disable iff (rst)
    uclk |=> $stable({en_fr, en_fn, en_slow}));
endmodule

bind ready_clkgen ready_clkgen_chk chk_i (
  .clk(clk), .rst(rst), .rdy_pos(rdy_pos), .rdy_neg(rdy_neg),
  .uclk(uclk), .clk_fr(clk_fr), .clk_fn(clk_fn), .clk_slow(clk_slow),
  .en_fr(en_fr), .en_fn(en_fn), .en_slow(en_slow)
);

// File: tb/ready_clkgen_tb_top.sv
module ready_clkgen_tb_top;
  localparam int N = 5;
  localparam int H = N / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rp = 1'b1, rn = 1'b1;
  logic uclk, fr, fn, sl, efr, efn, esl;

  ready_clkgen #(.RATIO(N)) dut_i (
    .clk(clk), .rst(rst), .rdy_pos(rp), .rdy_neg(rn),
    .uclk(uclk), .clk_fr(fr), .clk_fn(fn), .clk_slow(sl),
    .en_fr(efr), .en_fn(efn), .en_slow(esl)
  );

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic pu = 0, pfr = 0, pfn = 0, psl = 0;
  logic [2:0] pen = 0;
  int wfr, wxfr, wfnf, wxfnf, wfnr, wxfnr, wsr;
  int g = 0, asr = 0, asf = 0, off = 0, enoff = 0, badtog = 0;

  always @(posedge clk) begin
    #5;
    if (!rst) begin
      automatic bit ev = !pu;
      if (uclk == pu) badtog++;
      if (ev) begin
        if (rp) wxfr++;
        if (rn && pfn) wxfnf++;
        if (rp && rn) g++;
      end else if (!pfn) wxfnr++;
      if (fr && !pfr) begin wfr++; if (!ev) off++; end
      if (!fn && pfn) begin wfnf++; if (!ev) off++; end
      if (fn && !pfn) wfnr++;
      if (sl && !psl) begin asr++; wsr++; end
      if (!sl && psl) asf++;
      if (sl != psl && !ev) off++;
      if ({efr, efn, esl} != pen && !ev) enoff++;
    end
    pu = uclk; pfr = fr; pfn = fn; psl = sl; pen = {efr, efn, esl};
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic win(int n, bit p, bit q);
    @(negedge clk);
    rp = p; rn = q;
    wfr = 0; wxfr = 0; wfnf = 0; wxfnf = 0; wfnr = 0; wxfnr = 0; wsr = 0;
    repeat (2 * n) @(negedge clk);
    chk(wfr == wxfr, "R2", wfr, wxfr);
    chk(wfnf == wxfnf, "R3", wfnf, wxfnf);
    chk(wfnr == wxfnr, "R3", wfnr, wxfnr);
    chk(efr == p, "R7", efr, p);
    chk(efn == q, "R7", efn, q);
    chk(esl == (p & q), "R7", esl, p & q);
  endtask

  task automatic slow_totals();
    automatic int xr = (g + N - 1) / N;
    automatic int xf = (g > H) ? (g - 1 - H) / N + 1 : 0;
    chk(asr == xr, "R5", asr, xr);
    chk(asf == xf, "R5", asf, xf);
  endtask

  task automatic reset_check();
    chk(!uclk && !fr && !fn && !sl, "R8", {uclk, fr, fn, sl}, 0);
    chk(!efr && !efn && !esl, "R8", {efr, efn, esl}, 0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    reset_check();
    rst = 1'b0;

    // R4 ratio: 3N all-ready periods give three rising edges
    win(3 * N, 1, 1);
    chk(wsr == 3, "R4", wsr, 3);
    slow_totals();

    for (int o = 0; o < 2; o++)
      for (int len = 1; len <= 5; len++)
        for (int w = 0; w < 3; w++) begin
          if (o == 1) @(negedge clk);
          win(len, w == 1, w == 0);
          win(2, 1, 1);
          slow_totals();
        end

    // R4: both stalls low, slow clock frozen
    win(4, 0, 0);
    chk(wsr == 0, "R4", wsr, 0);
    slow_totals();

    win(3 * N, 1, 1);
    chk(wsr == 3, "R4", wsr, 3);

    // R8: reset in the middle of a run clears the phase
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    reset_check();
    g = 0; asr = 0; asf = 0;
    rst = 1'b0;
    win(N + 1, 1, 1);
    win(3, 1, 0);
    win(N, 1, 1);
    slow_totals();

    chk(off == 0, "R6", off, 0);
    chk(enoff == 0, "R7", enoff, 0);
    chk(badtog == 0, "R1", badtog, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule